// File: doc/BRIEF.md
# Wired Interrupt Aggregator

The block collects a bank of interrupt request lines (32 by default) into one wired interrupt line for a parent interrupt controller. Each line passes through a two-flop synchroniser. It is then recorded in a sticky pending register. One global control bit picks the recording rule for every line at the same time: either active-high level or rising edge. A per-line mask register gates which pending bits may drive the output. The output is a registered OR of every pending bit that is not masked.

Software uses a small word-addressed register port that has separate write and read strobes. To acknowledge a pending bit, software writes a zero to it in the pending register. Software can raise any line again through a separate write-only set register. The control register also holds a bit that disables message-signalled delivery. That bit is stored and read back, and it has no other effect.

Top module: `irq_gather_ctrl`

## Requirements
- R1: The 6-bit byte address decodes as follows: pending register at 0x00, set register at 0x08, mask register at 0x10, control register at 0x28. A read of 0x08 or of any other offset returns zero.
- R2: After reset, mask reads all ones, pending reads zero, control reads zero, and the interrupt output is low.
- R3: When control bit 3 is 1 (edge mode), a pending bit is set on a 0-to-1 transition of its synchronised line. It stays set until it is cleared. A line that stays high does not set the bit again after a clear.
- R4: When control bit 3 is 0 (level mode), a pending bit is set on every cycle its synchronised line is high. A clear therefore takes effect only after the line has dropped.
- R5: Writing the pending register clears each bit whose written value is 0 and leaves each bit whose written value is 1 unchanged.
- R6: Writing the set register sets each pending bit whose written value is 1. Bits written with 0 are not affected.
- R7: A mask bit of 1 blocks its line. The interrupt output is a register of the OR over (pending AND NOT mask).
- R8: Control bit 5 can be written and read back and has no other effect. All other control bits read zero.
- R9: A hardware set and a software clear of the same pending bit in the same cycle leave the bit set.
- R10: A line change reaches the pending register on the third clock edge after it is sampled. Reads return data in the cycle after the read strobe, and the read data holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Wired interrupt to the parent controller |

## Verification
A wrong pending bit shows up on the next read of offset 0x00. It also shows up on the interrupt output one cycle later, provided the bit is unmasked. A wrong mode bit changes when lines set their pending bits, and the difference is visible within three cycles of the next line transition. A lost or stuck mask bit shows as a wrong output level on the cycle after the pending state changes. Because the bench compares the output and the read data against a reference model on every clock, each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned REG_ADDR_W = 6;
  localparam logic [REG_ADDR_W-1:0] OFF_PEND = 6'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_SET  = 6'h08;
  localparam logic [REG_ADDR_W-1:0] OFF_MASK = 6'h10;
  localparam logic [REG_ADDR_W-1:0] OFF_CTRL = 6'h28;
  localparam int unsigned CTRL_EDGE_BIT = 3;
  localparam int unsigned CTRL_MSI_BIT  = 5;
  localparam int unsigned SYNC_STAGES   = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] lvl_o,
  output logic [N_SRC-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < N_SRC; g++) begin : g_line
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], src_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[LAST];
      end
    end

    assign lvl_o[g]  = chain_q[LAST];
    assign rise_o[g] = chain_q[LAST] & ~prev_q;
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_mode,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic [N_SRC-1:0] rise_i,
  input  logic             clr_we,
  input  logic             set_we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q, pend_d, hw_set, clr_bits, sw_bits;

  always_comb begin
    hw_set   = edge_mode ? rise_i : lvl_i;
    clr_bits = clr_we ? ~wdata : '0;
    sw_bits  = set_we ? wdata : '0;
    pend_d   = (pend_q & ~clr_bits) | sw_bits | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R5, R9: bits written 0 with no hardware set are low afterwards
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend_q & ~$past(wdata | lvl_i | rise_i)) == '0));
  // R5: without a clear write no pending bit ever falls
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R6: set register bits show in pending
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((pend_q & $past(wdata)) == $past(wdata)));
  // R4: level mode records every high synchronised line
  a_r4_level: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> ((pend_q & $past(lvl_i)) == $past(lvl_i)));
  // R3: edge mode records every rising synchronised line
  a_r3_edge: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      src_i,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]      wdata,
  output logic [N_SRC-1:0]      rdata,
  output logic                  irq_o
);
  logic             rst_i_n;
  logic [N_SRC-1:0] lvl, rise, pend;
  logic [N_SRC-1:0] mask_q, mask_d, rdata_d;
  logic             edge_q, edge_d, msi_q, msi_d, irq_d;
  logic             hit_pend, hit_set, hit_mask, hit_ctrl;

  irq_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  irq_src_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .src_i(src_i), .lvl_o(lvl), .rise_o(rise)
  );

  always_comb begin
    hit_pend = addr == OFF_PEND;
    hit_set  = addr == OFF_SET;
    hit_mask = addr == OFF_MASK;
    hit_ctrl = addr == OFF_CTRL;
  end

  irq_cause_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .edge_mode(edge_q),
    .lvl_i(lvl), .rise_i(rise),
    .clr_we(wr_en && hit_pend), .set_we(wr_en && hit_set),
    .wdata(wdata), .pend_o(pend)
  );

  always_comb begin
    mask_d = (wr_en && hit_mask) ? wdata : mask_q;
    edge_d = (wr_en && hit_ctrl) ? wdata[CTRL_EDGE_BIT] : edge_q;
    msi_d  = (wr_en && hit_ctrl) ? wdata[CTRL_MSI_BIT]  : msi_q;
    irq_d  = |(pend & ~mask_q);
    rdata_d = '0;
    if (hit_pend) rdata_d = pend;
    if (hit_mask) rdata_d = mask_q;
    if (hit_ctrl) begin
      rdata_d[CTRL_EDGE_BIT] = edge_q;
      rdata_d[CTRL_MSI_BIT]  = msi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mask_q <= '1;
      edge_q <= 1'b0;
      msi_q  <= 1'b0;
      irq_o  <= 1'b0;
      rdata  <= '0;
    end else begin
      mask_q <= mask_d;
      edge_q <= edge_d;
      msi_q  <= msi_d;
      irq_o  <= irq_d;
      if (rd_en) rdata <= rdata_d;
    end
  end

  // R7: all lines masked for two cycles keeps the output low
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (&mask_q && $past(&mask_q)) |-> !irq_o);
  // R7: nothing pending for two cycles keeps the output low
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pend == '0 && $past(pend == '0)) |-> !irq_o);
  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_en |=> $stable(rdata));
  // R1: a read of the set register returns zero
  a_r1_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && hit_set) |=> (rdata == '0));
endmodule

// File: tb/irq_gather_ctrl_tb.sv
module irq_gather_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R2";

  // reference state
  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_mask, m_ctrl, m_rdata;
  logic        m_irq;
  int          rcnt;

  always #2 clk = ~clk;

  irq_gather_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] read_model(input logic [5:0] a);
    case (a)
      6'h00:   return m_pend;
      6'h10:   return m_mask;
      6'h28:   return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] hw, np, nm, nc, nr;
    logic        ni;
    cycles++;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
      m_mask = '1; m_ctrl = 0; m_rdata = 0; m_irq = 0;
    end else begin
      hw = m_ctrl[3] ? (m_s2 & ~m_prev) : m_s2;
      np = m_pend; nm = m_mask; nc = m_ctrl; nr = m_rdata;
      if (wr_en && addr == 6'h00) np = np & wdata;
      if (wr_en && addr == 6'h08) np = np | wdata;
      np = np | hw;
      if (wr_en && addr == 6'h10) nm = wdata;
      if (wr_en && addr == 6'h28) nc = wdata & 32'h28;
      ni = |(m_pend & ~m_mask);
      if (rd_en) nr = read_model(addr);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = src;
      m_pend = np; m_mask = nm; m_ctrl = nc; m_irq = ni; m_rdata = nr;
    end
    #1;
    vectors++;
    if (irq_o !== m_irq) begin
      fails++;
      $display("FAIL %s irq_o actual=%b expected=%b t=%0t", cur_req, irq_o, m_irq, $time);
    end
    if (rdata !== m_rdata) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, m_rdata, $time);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    rcnt = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R2";
    rd(6'h10); rd(6'h00); rd(6'h28);
    cur_req = "R1";
    rd(6'h08); rd(6'h04); rd(6'h3C); rd(6'h2C);
    cur_req = "R8";
    wr(6'h28, 32'h20); rd(6'h28);
    wr(6'h28, 32'hFFFF_FFD7); rd(6'h28);
    wr(6'h28, 32'h20); rd(6'h28);
    cur_req = "R7";
    src = 32'h0000_0010; idle(5); rd(6'h00);
    wr(6'h10, 32'h0); idle(3);
    wr(6'h10, 32'hFFFF_FFEF); idle(3);
    wr(6'h10, 32'h0000_0010); idle(3);
    wr(6'h10, 32'h0);
    cur_req = "R4";
    src = 32'h0000_0008; idle(4);
    wr(6'h00, 32'h0); rd(6'h00);
    cur_req = "R9";
    wr(6'h00, 32'hFFFF_FFF7); rd(6'h00);
    cur_req = "R4";
    src = 32'h0; idle(4);
    wr(6'h00, 32'h0); rd(6'h00); idle(2);
    cur_req = "R3";
    wr(6'h28, 32'h08); wr(6'h00, 32'h0);
    src = 32'h0000_0300; idle(4); rd(6'h00);
    wr(6'h00, 32'h0); idle(4); rd(6'h00);
    src = 32'h0; idle(2); src = 32'h0000_0100; idle(4); rd(6'h00);
    cur_req = "R10";
    src = 32'h0; wr(6'h00, 32'h0);
    src = 32'h8000_0000; @(negedge clk); rd(6'h00); rd(6'h00); idle(3);
    cur_req = "R6";
    src = 32'h0; wr(6'h00, 32'h0);
    wr(6'h08, 32'h4000_0001); rd(6'h00); wr(6'h08, 32'h0); rd(6'h00);
    cur_req = "R5";
    wr(6'h00, 32'hFFFF_FFFE); rd(6'h00);
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00);
    cur_req = "R7";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      src = $urandom;
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      case ($urandom % 6)
        0: addr = 6'h00; 1: addr = 6'h08; 2: addr = 6'h10;
        3: addr = 6'h28; 4: addr = 6'h18; default: addr = 6'h00;
      endcase
      wdata = $urandom;
      if (addr == 6'h00 && ($urandom % 2) == 0) wdata = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule